// File: doc/BRIEF.md
# Command-Driven Wide Instruction Cache

This block holds a small set of wide instruction words. Which word sits in which entry is decided only by commands from the sequencer. The hardware never fills an entry, evicts one or chooses a victim. Because of this, the cycle in which every instruction issues is known at compile time, and the compiler can rewrite entries whenever it likes while the program runs.

The sequencer sends one command per cycle, and a command has one of two lengths. A long command carries a complete instruction word. The block can issue that word at once, save it into a numbered entry, or do both. A short command carries only an entry number, and the block issues the word stored there. The cache never has to be used: a program made only of immediate long commands works with every entry left empty.

Each command that executes produces exactly one word on the issue port, one cycle after the command is accepted. A write to an entry is held for one cycle in a commit register before it reaches the storage array. A read of an entry whose write is still pending gets the new data from that register. If a short command names an entry that was never written, the block issues an all-zero no-op and raises an error flag that stays set.

Top module: `cfg_icache`

## Requirements
- R1: After reset, `issue_valid` and `err_flag` are 0 and every entry is marked empty.
- R2: A command with opcode 00 (run immediate) issues `cmd_word` on `issue_word`, with `issue_valid` high, in the cycle after acceptance. It writes no entry.
- R3: A command with opcode 01 (run and keep) issues `cmd_word` one cycle later and also writes it into entry `cmd_idx`.
- R4: A command with opcode 10 (keep only) writes `cmd_word` into entry `cmd_idx` and issues nothing: `issue_valid` is 0 in the following cycle.
- R5: A command with opcode 11 (run from slot) issues the contents of entry `cmd_idx` in the cycle after acceptance, and `cmd_word` is ignored.
- R6: A run-from-slot command accepted in the cycle right after a write to the same entry issues the newly written data. A pending write to a different entry does not change the result.
- R7: A run-from-slot command on an empty entry issues an all-zero word with `issue_valid` high and sets `err_flag` in the same cycle.
- R8: Once `err_flag` is set, it stays set until reset.
- R9: An entry can be rewritten at any time, and later reads return the most recent data written to it.
- R10: A cycle with `cmd_valid` low produces `issue_valid` low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 2 | Opcode: 00 run immediate, 01 run and keep, 10 keep only, 11 run from slot |
| cmd_idx | input | $clog2(ENTRIES) | Entry number |
| cmd_word | input | WORD_W | Instruction word carried by long commands |
| issue_valid | output | 1 | A word is issued this cycle |
| issue_word | output | WORD_W | The issued instruction word |
| err_flag | output | 1 | Sticky flag: an empty entry was executed |

## Verification
The bench sends back-to-back writes and reads to one entry. A design without forwarding would return the old contents or a zero no-op at that point. It also sends two writes in a row to one entry and then reads it, which exposes a design that forwards from the wrong stage or lets the array win over the pending write. A read of one entry while a write to a different entry is pending checks that the forward compares the index and does not fire on every pending write. The bench also reads empty entries before and after a second reset, and confirms that an immediate command leaves its entry empty. A design that did not clear the valid bits, or that wrote on immediates, would issue stale data and never raise the flag.

// File: rtl/cfg_icache_pkg.sv
package cfg_icache_pkg;

    typedef enum logic [1:0] {
        OP_RUN_IMM  = 2'b00,
        OP_RUN_KEEP = 2'b01,
        OP_KEEP     = 2'b10,
        OP_RUN_SLOT = 2'b11
    } op_e;

    typedef struct packed {
        logic run;        // produces an issued word
        logic keep;       // writes the carried word into an entry
        logic from_slot;  // issued word comes from the cache
    } dec_t;

    function automatic dec_t decode_op(input op_e op);
        dec_t d;
        d.run       = (op != OP_KEEP);
        d.keep      = (op == OP_RUN_KEEP) || (op == OP_KEEP);
        d.from_slot = (op == OP_RUN_SLOT);
        return d;
    endfunction

endpackage

// File: rtl/ccache_decode.sv
module ccache_decode
    import cfg_icache_pkg::*;
(
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    output dec_t       dec
);
    dec_t raw;

    always_comb begin
        raw = decode_op(op_e'(cmd_op));
        dec.run       = cmd_valid & raw.run;
        dec.keep      = cmd_valid & raw.keep;
        dec.from_slot = cmd_valid & raw.from_slot;
    end
endmodule

// File: rtl/ccache_store.sv
module ccache_store #(
    parameter int ENTRIES = 16,
    parameter int WORD_W  = 256,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_word,
    output logic              rd_ok
);
    logic [WORD_W-1:0]  mem [ENTRIES];
    logic [ENTRIES-1:0] vld;

    // commit stage: a write sits here one cycle before reaching the array
    logic               pend_v;
    logic [IDX_W-1:0]   pend_idx;
    logic [WORD_W-1:0]  pend_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v   <= 1'b0;
            pend_idx <= '0;
        end else begin
            pend_v   <= wr_en;
            pend_idx <= wr_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) pend_word <= wr_word;
    end

    always_ff @(posedge clk) begin
        if (pend_v) mem[pend_idx] <= pend_word;
    end

    always_ff @(posedge clk) begin
        if (rst) vld <= '0;
        else if (pend_v) vld[pend_idx] <= 1'b1;
    end

    logic fwd;

    always_comb begin
        fwd = pend_v && (pend_idx == rd_idx);
        if (fwd) begin
            rd_word = pend_word;
            rd_ok   = 1'b1;
        end else begin
            rd_word = mem[rd_idx];
            rd_ok   = vld[rd_idx];
        end
    end
endmodule

// File: rtl/ccache_issue.sv
module ccache_issue #(
    parameter int WORD_W = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              from_slot,
    input  logic [WORD_W-1:0] imm_word,
    input  logic [WORD_W-1:0] slot_word,
    input  logic              slot_ok,
    output logic              issue_valid,
    output logic [WORD_W-1:0] issue_word,
    output logic              err_flag
);
    logic [WORD_W-1:0] next_word;
    logic              miss;

    always_comb begin
        miss = run && from_slot && !slot_ok;
        if (!from_slot)   next_word = imm_word;
        else if (slot_ok) next_word = slot_word;
        else              next_word = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            issue_valid <= 1'b0;
            issue_word  <= '0;
            err_flag    <= 1'b0;
        end else begin
            issue_valid <= run;
            if (run)  issue_word <= next_word;
            if (miss) err_flag   <= 1'b1;
        end
    end
endmodule

// File: rtl/cfg_icache.sv
module cfg_icache
    import cfg_icache_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int WORD_W  = 256,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [IDX_W-1:0]  cmd_idx,
    input  logic [WORD_W-1:0] cmd_word,
    output logic              issue_valid,
    output logic [WORD_W-1:0] issue_word,
    output logic              err_flag
);
    dec_t              dec;
    logic [WORD_W-1:0] slot_word;
    logic              slot_ok;

    ccache_decode u_dec (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .dec       (dec)
    );

    ccache_store #(.ENTRIES(ENTRIES), .WORD_W(WORD_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (dec.keep),
        .wr_idx  (cmd_idx),
        .wr_word (cmd_word),
        .rd_idx  (cmd_idx),
        .rd_word (slot_word),
        .rd_ok   (slot_ok)
    );

    ccache_issue #(.WORD_W(WORD_W)) u_issue (
        .clk         (clk),
        .rst         (rst),
        .run         (dec.run),
        .from_slot   (dec.from_slot),
        .imm_word    (cmd_word),
        .slot_word   (slot_word),
        .slot_ok     (slot_ok),
        .issue_valid (issue_valid),
        .issue_word  (issue_word),
        .err_flag    (err_flag)
    );
endmodule

// File: rtl/cfg_icache_chk.sv
module cfg_icache_chk #(
    parameter int IDX_W  = 4,
    parameter int WORD_W = 256
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic [1:0]        cmd_op,
    input logic [IDX_W-1:0]  cmd_idx,
    input logic [WORD_W-1:0] cmd_word,
    input logic              issue_valid,
    input logic [WORD_W-1:0] issue_word,
    input logic              err_flag
);
    // R2
    imm_word_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 2'b00) |=> (issue_valid && issue_word == $past(cmd_word)));

    // R3
    keep_run_word_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 2'b01) |=> (issue_valid && issue_word == $past(cmd_word)));

    // R4
    keep_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 2'b10) |=> !issue_valid);

    // R5
    slot_issue_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 2'b11) |=> issue_valid);

    // R7
    miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err_flag) |-> (issue_valid && issue_word == '0 && $past(cmd_valid && cmd_op == 2'b11)));

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> err_flag);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> !issue_valid);
endmodule

bind cfg_icache cfg_icache_chk #(.IDX_W(IDX_W), .WORD_W(WORD_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_idx     (cmd_idx),
    .cmd_word    (cmd_word),
    .issue_valid (issue_valid),
    .issue_word  (issue_word),
    .err_flag    (err_flag)
);

// File: tb/sim_cfg_icache.sv
module sim_cfg_icache;
    localparam int ENTRIES = 16;
    localparam int WORD_W  = 256;
    localparam int IDX_W   = $clog2(ENTRIES);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cmd_valid = 1'b0;
    logic [1:0]        cmd_op = '0;
    logic [IDX_W-1:0]  cmd_idx = '0;
    logic [WORD_W-1:0] cmd_word = '0;
    logic              issue_valid;
    logic [WORD_W-1:0] issue_word;
    logic              err_flag;

    cfg_icache #(.ENTRIES(ENTRIES), .WORD_W(WORD_W)) u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_idx(cmd_idx), .cmd_word(cmd_word), .issue_valid(issue_valid),
        .issue_word(issue_word), .err_flag(err_flag)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [WORD_W-1:0] exp_q[$];
    string             tag_q[$];
    logic [WORD_W-1:0] model_mem [ENTRIES];
    logic [ENTRIES-1:0] model_vld = '0;

    task automatic chk(input bit ok, input string tag, input logic [WORD_W-1:0] act,
                       input logic [WORD_W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [WORD_W-1:0] mkw(input logic [31:0] s);
        logic [WORD_W-1:0] w;
        for (int i = 0; i < WORD_W / 32; i++) w[i*32 +: 32] = s ^ (32'h9e37_79b9 * (i + 1));
        return w;
    endfunction

    task automatic send(input logic [1:0] op, input int idx, input logic [WORD_W-1:0] w,
                        input string tag);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_idx   = IDX_W'(idx);
        cmd_word  = w;
        if (op == 2'b00 || op == 2'b01) begin
            exp_q.push_back(w);
            tag_q.push_back(tag);
        end else if (op == 2'b11) begin
            exp_q.push_back(model_vld[idx] ? model_mem[idx] : '0);
            tag_q.push_back(tag);
        end
        if (op == 2'b01 || op == 2'b10) begin
            model_mem[idx] = w;
            model_vld[idx] = 1'b1;
        end
        @(posedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cmd_valid = 1'b0;
            @(posedge clk);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && issue_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4/R10 unexpected issue", issue_word, '0);
            end else begin
                logic [WORD_W-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(issue_word == e, t, issue_word, e);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", '0, '0);
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(issue_valid == 1'b0, "R1 issue_valid", WORD_W'(issue_valid), '0);
        chk(err_flag == 1'b0, "R1 err_flag", WORD_W'(err_flag), '0);
        // R10 idle
        chk(issue_valid == 1'b0, "R10 idle", WORD_W'(issue_valid), '0);

        // R1/R7: empty entry issues zero and raises the flag
        send(2'b11, 5, mkw(32'h1111), "R7 empty slot word");
        @(negedge clk);
        chk(err_flag == 1'b1, "R7 err raised", WORD_W'(err_flag), WORD_W'(1));
        cmd_valid = 1'b0;
        @(posedge clk);

        send(2'b00, 0, mkw(32'hA0), "R2 immediate");
        send(2'b01, 2, mkw(32'hA1), "R3 run and keep");
        send(2'b10, 7, mkw(32'hA2), "R4 keep only");
        @(negedge clk);
        chk(issue_valid == 1'b0, "R4 no issue", WORD_W'(issue_valid), '0);
        cmd_valid = 1'b0;
        @(posedge clk);
        idle(2);
        send(2'b11, 2, mkw(32'hFFFF), "R3/R5 slot 2");
        send(2'b11, 7, '0, "R4/R5 slot 7");
        send(2'b11, 0, mkw(32'hA0), "R2 immediate left entry empty");

        // R6 forwarding
        send(2'b10, 9, mkw(32'hB4), "R6 store");
        send(2'b11, 9, '0, "R6 forward same cycle");
        send(2'b10, 9, mkw(32'hB5), "R6 store");
        send(2'b10, 9, mkw(32'hB6), "R6 store");
        send(2'b11, 9, '0, "R6 latest of two writes");
        send(2'b10, 4, mkw(32'hB8), "R6 store other");
        send(2'b11, 9, '0, "R6 pending other index");
        // R9 rewrite
        send(2'b01, 2, mkw(32'hB7), "R9 rewrite run");
        idle(3);
        send(2'b11, 2, '0, "R9 rewritten slot");
        send(2'b11, 4, '0, "R9 slot 4");
        idle(2);
        @(negedge clk);
        chk(err_flag == 1'b1, "R8 sticky", WORD_W'(err_flag), WORD_W'(1));
        chk(exp_q.size() == 0, "R5 all issued", WORD_W'(exp_q.size()), '0);

        // second reset clears flag and entries
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_vld = '0;
        @(negedge clk);
        chk(err_flag == 1'b0, "R1 err cleared", WORD_W'(err_flag), '0);
        chk(issue_valid == 1'b0, "R1 valid cleared", WORD_W'(issue_valid), '0);
        send(2'b11, 2, '0, "R1 entry emptied by reset");
        @(negedge clk);
        chk(err_flag == 1'b1, "R7 err after reset", WORD_W'(err_flag), WORD_W'(1));
        cmd_valid = 1'b0;
        @(posedge clk);
        idle(2);
        chk(exp_q.size() == 0, "R7 all issued", WORD_W'(exp_q.size()), '0);
        finish_run();
    end
endmodule